// File: doc/BRIEF.md
# HDLC Receive Character Buffer with Per-Character Status

This block holds received characters between the deserializer of an HDLC receiver and the host. Each character enters with its own status: an end-of-message marker and, on the closing character of a frame, the 16-bit frame check residue. A status FIFO is kept beside the data FIFO. Both share one pair of pointers, so every stored character keeps its own end-of-message, CRC-error and overrun bits until the host takes it.

When a character arrives and every stage is already occupied, the newest stored character is replaced. Its stage takes the new character, an overrun mark, and a cleared end-of-message bit. Errors are reported to the host only when the affected character is read. One cycle after such a character shows up on the read port, its error bits are merged into sticky flags. The sticky flags drive a registered interrupt through individual enables. The host clears each flag by pulsing its clear input.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: After synchronous reset, `avail`, `full`, `ovr_flag`, `crc_flag` and `irq` are 0 and `rd_data` is 0.
- R2: Characters are returned in arrival order. A `rd_req` pulse sampled on a clock edge while `avail` is 1 puts the oldest character on `rd_data` and its end-of-message bit on `rd_eom` after that same edge. A `rd_req` while `avail` is 0 leaves `rd_data` unchanged.
- R3: `avail` is 1 whenever at least one unread character is stored. `full` is 1 exactly when DEPTH (default 4) unread characters are stored.
- R4: A write arriving while `full` is 1 with no read in the same cycle replaces the most recently stored character. The older characters are kept and the number stored does not change.
- R5: A character stored by such an overrun write always reads back with `rd_eom` = 0, even if `in_eom` was 1.
- R6: `ovr_flag` rises one cycle after the overwritten character appears on `rd_data`. It does not rise when characters written before the overrun are read.
- R7: `ovr_flag` stays 1 until a cycle with `clr_ovr` = 1, or until reset. Later clean characters do not clear it. If a set and a clear fall in the same cycle, the set wins. `clr_crc` acts the same way on `crc_flag`.
- R8: A character written with `in_eom` = 1, `crc_chk_en` = 1 and `in_crc_res` not equal to 16'h1D0F sets `crc_flag` one cycle after it appears on `rd_data`. A residue of 16'h1D0F, or `in_eom` = 0, leaves `crc_flag` unchanged.
- R9: A character written while `crc_chk_en` = 0 never sets `crc_flag`, whatever its residue.
- R10: `irq` is a registered copy of (`ovr_flag` AND `ovr_ie`) OR (`crc_flag` AND `crc_ie`). It follows changes of the flags on the same clock edge, and follows changes of the enables one edge later.
- R11: A write and a read in the same cycle while `full` is 1 is not an overrun. The oldest character is read, the new one is appended, and `full` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Character strobe from the deserializer |
| in_data | input | DW | Received character |
| in_eom | input | 1 | Character closes a frame |
| in_crc_res | input | 16 | CRC residue, meaningful with in_eom |
| crc_chk_en | input | 1 | CRC checking mode, sampled with each character |
| rd_req | input | 1 | Host read strobe |
| clr_ovr | input | 1 | Clear sticky overrun flag |
| clr_crc | input | 1 | Clear sticky CRC-error flag |
| ovr_ie | input | 1 | Overrun interrupt enable |
| crc_ie | input | 1 | CRC-error interrupt enable |
| rd_data | output | DW | Last character read |
| rd_eom | output | 1 | End-of-message bit of the last character read |
| avail | output | 1 | At least one character stored |
| full | output | 1 | All stages occupied |
| ovr_flag | output | 1 | Sticky overrun status |
| crc_flag | output | 1 | Sticky CRC-error status |
| irq | output | 1 | Interrupt request |

## Verification
A pointer or count that has drifted shows up as a character read out of order or a missing character. It also shows up as `full` or `avail` being wrong on the very next edge. A status FIFO that falls out of step with the data shows up as `ovr_flag`, `crc_flag` or `rd_eom` attached to the wrong character. This is visible one cycle after that character is read. For that reason, each flag is checked both just before and just after the cycle in which it is due. A clear or set priority error shows on the flag and on `irq` within one edge.

// File: rtl/hdlc_rxf_pkg.sv
package hdlc_rxf_pkg;
  typedef struct packed {
    logic eom;
    logic crc_err;
    logic ovr;
  } rx_stat_t;

  localparam int STAT_W = $bits(rx_stat_t);
  localparam logic [15:0] CRC_GOOD_RES = 16'h1D0F;
endpackage

// File: rtl/hdlc_rxf_ram.sv
module hdlc_rxf_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/hdlc_rxf_ctrl.sv
module hdlc_rxf_ctrl #(
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic          rd_req,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          ovr_wr,
  output logic          pop,
  output logic [AW-1:0] raddr,
  output logic          avail,
  output logic          full
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wptr, rptr, wptr_prev;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          push;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
    return (p == '0) ? PTR_LAST : p - AW'(1);
  endfunction

  always_comb begin
    pop       = rd_req && (cnt != '0);
    ovr_wr    = in_vld && (cnt == CNT_FULL) && !pop;
    push      = in_vld && !ovr_wr;
    we        = in_vld;
    wptr_prev = ptr_dec(wptr);
    waddr     = ovr_wr ? wptr_prev : wptr;
    raddr     = rptr;
    cnt_nxt   = cnt;
    if (push) cnt_nxt = cnt_nxt + CW'(1);
    if (pop)  cnt_nxt = cnt_nxt - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt   <= '0;
      avail <= 1'b0;
      full  <= 1'b0;
    end else begin
      if (push) wptr <= ptr_inc(wptr);
      if (pop)  rptr <= ptr_inc(rptr);
      cnt   <= cnt_nxt;
      avail <= (cnt_nxt != '0);
      full  <= (cnt_nxt == CNT_FULL);
    end
  end
endmodule

// File: rtl/hdlc_rxf_sticky.sv
module hdlc_rxf_sticky
  import hdlc_rxf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     pop,
  input  rx_stat_t st,
  input  logic     clr_ovr,
  input  logic     clr_crc,
  input  logic     ovr_ie,
  input  logic     crc_ie,
  output logic     ovr_flag,
  output logic     crc_flag,
  output logic     irq
);
  logic pop_q;
  logic ovr_nxt, crc_nxt;

  always_comb begin
    ovr_nxt = (pop_q && st.ovr)     || (ovr_flag && !clr_ovr);
    crc_nxt = (pop_q && st.crc_err) || (crc_flag && !clr_crc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_q    <= 1'b0;
      ovr_flag <= 1'b0;
      crc_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      pop_q    <= pop;
      ovr_flag <= ovr_nxt;
      crc_flag <= crc_nxt;
      irq      <= (ovr_nxt && ovr_ie) || (crc_nxt && crc_ie);
    end
  end
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
  import hdlc_rxf_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          DEPTH    = 4,
  parameter logic [15:0] GOOD_RES = CRC_GOOD_RES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  input  logic          in_eom,
  input  logic [15:0]   in_crc_res,
  input  logic          crc_chk_en,
  input  logic          rd_req,
  input  logic          clr_ovr,
  input  logic          clr_crc,
  input  logic          ovr_ie,
  input  logic          crc_ie,
  output logic [DW-1:0] rd_data,
  output logic          rd_eom,
  output logic          avail,
  output logic          full,
  output logic          ovr_flag,
  output logic          crc_flag,
  output logic          irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          we, ovr_wr, pop;
  logic [AW-1:0] waddr, raddr;
  rx_stat_t      wst, rst_out;

  hdlc_rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .in_vld(in_vld), .rd_req(rd_req),
    .we(we), .waddr(waddr), .ovr_wr(ovr_wr), .pop(pop), .raddr(raddr),
    .avail(avail), .full(full)
  );

  always_comb begin
    wst.eom     = in_eom && !ovr_wr;
    wst.crc_err = in_eom && crc_chk_en && (in_crc_res != GOOD_RES);
    wst.ovr     = ovr_wr;
  end

  hdlc_rxf_ram #(.W(DW), .DEPTH(DEPTH)) u_data_ram (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(in_data),
    .re(pop), .raddr(raddr), .rdata(rd_data)
  );

  hdlc_rxf_ram #(.W(STAT_W), .DEPTH(DEPTH)) u_stat_ram (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wst),
    .re(pop), .raddr(raddr), .rdata(rst_out)
  );

  assign rd_eom = rst_out.eom;

  hdlc_rxf_sticky u_sticky (
    .clk(clk), .rst(rst), .pop(pop), .st(rst_out),
    .clr_ovr(clr_ovr), .clr_crc(clr_crc), .ovr_ie(ovr_ie), .crc_ie(crc_ie),
    .ovr_flag(ovr_flag), .crc_flag(crc_flag), .irq(irq)
  );
endmodule

// File: rtl/hdlc_rx_fifo_chk.sv
module hdlc_rx_fifo_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_vld,
  input logic          rd_req,
  input logic          clr_ovr,
  input logic          ovr_ie,
  input logic          crc_ie,
  input logic          avail,
  input logic          full,
  input logic [DW-1:0] rd_data,
  input logic          ovr_flag,
  input logic          crc_flag,
  input logic          irq
);
  assert_full_has_data_R3: assert property (@(posedge clk) disable iff (rst)
    full |-> avail);

  assert_rd_data_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(rd_data));

  assert_read_frees_stage_R11: assert property (@(posedge clk) disable iff (rst)
    (full && rd_req && !in_vld) |=> !full);

  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (ovr_flag && !clr_ovr) |=> ovr_flag);

  assert_ovr_after_read_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr_flag) |-> $past(rd_req, 2));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((ovr_flag && $past(ovr_ie)) || (crc_flag && $past(crc_ie))));
endmodule

bind hdlc_rx_fifo hdlc_rx_fifo_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .rd_req(rd_req),
  .clr_ovr(clr_ovr), .ovr_ie(ovr_ie), .crc_ie(crc_ie),
  .avail(avail), .full(full), .rd_data(rd_data),
  .ovr_flag(ovr_flag), .crc_flag(crc_flag), .irq(irq)
);

// File: tb/hdlc_rx_fifo_tb.sv
module hdlc_rx_fifo_tb;
  localparam logic [15:0] GOOD = 16'h1D0F;
  localparam logic [15:0] BAD  = 16'hBEEF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0, in_eom = 1'b0, crc_chk_en = 1'b0, rd_req = 1'b0;
  logic [7:0]  in_data = '0;
  logic [15:0] in_crc_res = '0;
  logic        clr_ovr = 1'b0, clr_crc = 1'b0, ovr_ie = 1'b0, crc_ie = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_eom, avail, full, ovr_flag, crc_flag, irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hdlc_rx_fifo u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data), .in_eom(in_eom),
    .in_crc_res(in_crc_res), .crc_chk_en(crc_chk_en), .rd_req(rd_req),
    .clr_ovr(clr_ovr), .clr_crc(clr_crc), .ovr_ie(ovr_ie), .crc_ie(crc_ie),
    .rd_data(rd_data), .rd_eom(rd_eom), .avail(avail), .full(full),
    .ovr_flag(ovr_flag), .crc_flag(crc_flag), .irq(irq)
  );

  // vector: [20] read, [19:12] data, [11] eom, [10] bad residue, [9] crc en,
  //         [8:1] expected read data, [0] expected eom
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 8'hA1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0},
    {1'b0, 8'hB2, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0},
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'hA1, 1'b0},
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'hB2, 1'b1},
    {1'b0, 8'h33, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0},
    {1'b0, 8'h44, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0},
    {1'b0, 8'h55, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0},
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h33, 1'b0},
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h44, 1'b0},
    {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h55, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wr(input logic [7:0] d, input logic e, input logic [15:0] res, input logic en);
    in_vld = 1'b1; in_data = d; in_eom = e; in_crc_res = res; crc_chk_en = en;
    @(negedge clk);
    in_vld = 1'b0; in_eom = 1'b0;
  endtask

  task automatic rd;
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      report;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 avail", avail, 0);
    check("R1 full", full, 0);
    check("R1 flags", {ovr_flag, crc_flag, irq}, 0);
    check("R1 rd_data", rd_data, 0);

    // R2 ordering and end-of-message via the vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        rd;
        check($sformatf("R2 vec%0d data", i), rd_data, VEC[i][8:1]);
        check($sformatf("R2 vec%0d eom", i), rd_eom, VEC[i][0]);
      end else begin
        wr(VEC[i][19:12], VEC[i][11], VEC[i][10] ? BAD : GOOD, VEC[i][9]);
      end
    end
    @(negedge clk);
    check("R8 bad residue sets crc_flag", crc_flag, 1);
    check("R10 irq masked", irq, 0);
    crc_ie = 1'b1;
    @(negedge clk);
    check("R10 irq crc enabled", irq, 1);
    clr_crc = 1'b1; @(negedge clk); clr_crc = 1'b0;
    check("R7 clr_crc", crc_flag, 0);
    check("R10 irq after clear", irq, 0);

    // R2 read while empty
    check("R3 empty avail", avail, 0);
    rd;
    check("R2 empty read holds", rd_data, 8'h55);

    // R9 check disabled
    wr(8'h61, 1'b1, BAD, 1'b0);
    rd; @(negedge clk);
    check("R9 disabled no crc", crc_flag, 0);
    // R8 good residue and non-eom bad residue
    wr(8'h62, 1'b1, GOOD, 1'b1);
    wr(8'h63, 1'b0, BAD, 1'b1);
    rd; rd; @(negedge clk);
    check("R8 good/non-eom no crc", crc_flag, 0);

    // R4 R5 R6 overrun
    wr(8'h11, 1'b0, GOOD, 1'b1);
    wr(8'h22, 1'b0, GOOD, 1'b1);
    wr(8'h33, 1'b0, GOOD, 1'b1);
    check("R3 not full at 3", full, 0);
    wr(8'h44, 1'b0, GOOD, 1'b1);
    check("R3 full at 4", full, 1);
    wr(8'h55, 1'b1, GOOD, 1'b1);
    check("R4 still full", full, 1);
    rd; check("R4 oldest kept", rd_data, 8'h11);
    rd; check("R4 second kept", rd_data, 8'h22);
    rd; check("R4 third kept", rd_data, 8'h33);
    @(negedge clk);
    check("R6 no early ovr", ovr_flag, 0);
    rd;
    check("R4 newest replaced", rd_data, 8'h55);
    check("R5 eom cleared", rd_eom, 0);
    check("R6 ovr not yet", ovr_flag, 0);
    @(negedge clk);
    check("R6 ovr set", ovr_flag, 1);
    check("R3 drained", avail, 0);

    // R7 sticky and priority, R10 irq
    wr(8'h66, 1'b0, GOOD, 1'b1);
    rd; @(negedge clk);
    check("R7 clean char keeps ovr", ovr_flag, 1);
    ovr_ie = 1'b1;
    @(negedge clk);
    check("R10 irq ovr enabled", irq, 1);
    clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0;
    check("R7 clr_ovr", ovr_flag, 0);
    check("R10 irq drops", irq, 0);

    // R11 simultaneous write and read while full
    wr(8'hA0, 1'b0, GOOD, 1'b1);
    wr(8'hA1, 1'b0, GOOD, 1'b1);
    wr(8'hA2, 1'b0, GOOD, 1'b1);
    wr(8'hA3, 1'b0, GOOD, 1'b1);
    in_vld = 1'b1; in_data = 8'hA4; rd_req = 1'b1;
    @(negedge clk);
    in_vld = 1'b0; rd_req = 1'b0;
    check("R11 read oldest", rd_data, 8'hA0);
    check("R11 stays full", full, 1);
    rd; check("R11 a1", rd_data, 8'hA1);
    rd; check("R11 a2", rd_data, 8'hA2);
    rd; check("R11 a3", rd_data, 8'hA3);
    rd; check("R11 a4 appended", rd_data, 8'hA4);
    @(negedge clk);
    check("R11 no overrun", ovr_flag, 0);

    // R7 set wins over clear in the same cycle
    wr(8'h01, 1'b0, GOOD, 1'b1); wr(8'h02, 1'b0, GOOD, 1'b1);
    wr(8'h03, 1'b0, GOOD, 1'b1); wr(8'h04, 1'b0, GOOD, 1'b1);
    wr(8'h05, 1'b0, GOOD, 1'b1);
    rd; rd; rd; rd;
    clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0;
    check("R7 set beats clear", ovr_flag, 1);

    // R1 reset mid-run
    wr(8'h77, 1'b0, GOOD, 1'b1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 reset clears avail", avail, 0);
    check("R1 reset clears ovr", ovr_flag, 0);

    done = 1'b1;
    report;
  end
endmodule